// File: doc/BRIEF.md
# ADC Direct-Read Serial Output Shifter

This block is the output side of a converter's serial port in a read mode that needs no command. Each time the converter produces a result, the block captures a frame into its output register and pulls its ready indication low. The host then applies serial clocks and the frame shifts out MSB first. The frame holds an optional status byte, the conversion word and an optional CRC-8 byte. If the host keeps clocking after the last bit, the same frame starts again from its first bit, so the host can read it twice and compare the copies.

The data-out line also carries the ready indication. While chip select is low and no bit of the current frame has been shifted yet, the line shows the ready level. The port is full duplex. Bits on data-in are collected into bytes during the read, and any complete non-zero byte is passed to an outside command decoder as a one-cycle flag. A serial-clock edge that comes after a result is loaded but before chip select goes low marks that result as unreliable.

All pins are sampled in the block's own clock domain through a synchronizer of configurable depth. The output enable stands in for the high-impedance state of the shared pin.

Top module: `adc_readback_shifter`

## Requirements
- R1: The frame is, in order, the status byte (only when `en_status` is 1), the conversion word, then the CRC byte (only when `en_crc` is 1). Each part is sent MSB first. The frame length is WORD_W + 8·en_status + 8·en_crc bits.
- R2: After the last bit of the frame, further serial rising edges send the frame again from its first bit, and keep doing so.
- R3: `drdy_n` is driven low on the clock after a `res_stb` pulse. It returns high after the first serial-clock falling edge that follows.
- R4: `dout_oe` is 1 exactly while chip select is low. While chip select is low and no rising edge has occurred since the last load or since chip select fell, `dout` equals `drdy_n`. From the first such rising edge on, it carries frame bits, which change on serial rising edges (SPI mode 1).
- R5: The CRC byte is CRC-8 with polynomial 0x07 (x^8+x^2+x+1) and initial value 0. It is computed MSB first over the status byte (when enabled) followed by the word bytes, most significant byte first.
- R6: `din` is sampled on serial falling edges while chip select is low and assembled MSB first into bytes, with the count starting when chip select falls. For each complete non-zero byte, `cmd_seen` pulses for one clock and `cmd_byte` holds that byte. An all-zero byte gives no pulse.
- R7: `data_invalid` is set when a serial-clock edge occurs after a load but before the first edge seen with chip select low. It is cleared by the next load, and a normal read leaves it clear.
- R8: Chip select high sets the read position back to the first bit of the frame.
- R9: A load during a read replaces the frame. The next rising edge sends the first bit of the new frame.
- R10: After reset: `drdy_n`=1, `dout_oe`=0, `cmd_seen`=0, `data_invalid`=0, and the stored frame is all zero.
- R11: `en_status` and `en_crc` are captured at load time. Changing them afterwards does not alter the frame being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data from host |
| res_stb | input | 1 | One-cycle strobe: new conversion result |
| res_word | input | WORD_W | Conversion word |
| res_status | input | 8 | Status byte captured with the result |
| en_status | input | 1 | Include status byte in frame |
| en_crc | input | 1 | Include CRC byte in frame |
| dout | output | 1 | Combined data-out / ready line |
| dout_oe | output | 1 | Drive enable for dout (0 = high impedance) |
| drdy_n | output | 1 | Ready, active low |
| cmd_seen | output | 1 | One-cycle flag: non-zero command byte received |
| cmd_byte | output | 8 | Last non-zero byte received |
| data_invalid | output | 1 | Serial activity seen before the read of the current result |

## Verification
The hardest cases to reach are the interleavings between result loads and host clocking. One is a load that arrives halfway through a frame. Another is serial clocking while chip select is still high, right after a load. The bench drives the serial pins from tasks with a slow, fixed half period and issues `res_stb` between those tasks, so it can place a load or a stray edge at any bit position. A queue-based model of the expected frame, with its own CRC, predicts every bit, and each bit is sampled at the end of its high phase. Command detection is covered by the same reads, with an all-zero byte and a non-zero byte placed on data-in.

// File: rtl/rb_pkg.sv
package rb_pkg;
   localparam logic [7:0] CRC8_POLY = 8'h07;

   function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in, input logic [7:0] data);
      logic [7:0] c;
      c = crc_in;
      for (int b = 7; b >= 0; b--) begin
         if (c[7] ^ data[b]) c = {c[6:0], 1'b0} ^ CRC8_POLY;
         else                c = {c[6:0], 1'b0};
      end
      return c;
   endfunction
endpackage

// File: rtl/rb_in_sync.sv
module rb_in_sync #(
   parameter int              STAGES = 2,
   parameter int              W      = 3,
   parameter logic [W-1:0]    RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rb_crc8.sv
module rb_crc8 import rb_pkg::*; #(
   parameter int NBYTES = 3
) (
   input  logic [8*NBYTES-1:0] data,
   output logic [7:0]          crc
);
   logic [7:0] chain [NBYTES+1];
   assign chain[0] = 8'h00;
   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_stage
         assign chain[g+1] = crc8_byte(chain[g], data[8*(NBYTES-g)-1 -: 8]);
      end
   endgenerate
   assign crc = chain[NBYTES];
endmodule

// File: rtl/rb_cmd_snoop.sv
module rb_cmd_snoop (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_act,
   input  logic       sclk_fall,
   input  logic       din_s,
   output logic       cmd_seen,
   output logic [7:0] cmd_byte
);
   logic [6:0] sh_q;
   logic [2:0] cnt_q;
   logic [7:0] next_byte;

   assign next_byte = {sh_q, din_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         cnt_q    <= '0;
         cmd_seen <= 1'b0;
         cmd_byte <= '0;
      end else begin
         cmd_seen <= 1'b0;
         if (!cs_act) begin
            cnt_q <= '0;
         end else if (sclk_fall) begin
            sh_q  <= next_byte[6:0];
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7 && next_byte != 8'h00) begin
               cmd_seen <= 1'b1;
               cmd_byte <= next_byte;
            end
         end
      end
   end
endmodule

// File: rtl/adc_readback_shifter.sv
module adc_readback_shifter import rb_pkg::*; #(
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              din,
   input  logic              res_stb,
   input  logic [WORD_W-1:0] res_word,
   input  logic [7:0]        res_status,
   input  logic              en_status,
   input  logic              en_crc,
   output logic              dout,
   output logic              dout_oe,
   output logic              drdy_n,
   output logic              cmd_seen,
   output logic [7:0]        cmd_byte,
   output logic              data_invalid
);
   localparam int WBYTES    = WORD_W / 8;
   localparam int FRAME_MAX = WORD_W + 16;
   localparam int CNT_W     = $clog2(FRAME_MAX);

   generate
      if (WORD_W < 8 || (WORD_W % 8) != 0) begin : g_bad_width
         $error("WORD_W must be a non-zero multiple of 8");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   // input synchronisation and serial-clock edge detection
   logic [2:0] pins_s;
   logic       cs_n_s, sclk_s, din_s, sclk_d;
   logic       cs_act, sclk_rise, sclk_fall;

   rb_in_sync #(.STAGES(SYNC_STAGES), .W(3), .RST(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, din}), .q(pins_s));

   assign {cs_n_s, sclk_s, din_s} = pins_s;
   assign cs_act    = ~cs_n_s;
   assign sclk_rise =  sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s &  sclk_d;

   // frame assembly with CRC
   logic [7:0]           crc_val;
   logic [FRAME_MAX-1:0] frame_d;
   logic [CNT_W:0]       len_d;

   rb_crc8 #(.NBYTES(WBYTES + 1)) u_crc (
      .data({(en_status ? res_status : 8'h00), res_word}),
      .crc (crc_val));

   always_comb begin
      unique case ({en_status, en_crc})
         2'b11:   frame_d = {res_status, res_word, crc_val};
         2'b10:   frame_d = {res_status, res_word, 8'h00};
         2'b01:   frame_d = {res_word, crc_val, 8'h00};
         default: frame_d = {res_word, 16'h0000};
      endcase
      len_d = (CNT_W+1)'(WORD_W) + (en_status ? (CNT_W+1)'(8) : '0)
                                 + (en_crc    ? (CNT_W+1)'(8) : '0);
   end

   // output shifting state
   logic [FRAME_MAX-1:0] frame_q;
   logic [CNT_W:0]       len_q;
   logic [CNT_W-1:0]     bit_pos;
   logic [CNT_W-1:0]     bit_idx;
   logic                 dout_q, shifting, drdy_q, pend_q, inval_q;
   logic                 last_bit;

   assign bit_idx  = CNT_W'(FRAME_MAX - 1) - bit_pos;
   assign last_bit = ({1'b0, bit_pos} == len_q - (CNT_W+1)'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         frame_q  <= '0;
         len_q    <= (CNT_W+1)'(WORD_W);
         bit_pos  <= '0;
         dout_q   <= 1'b0;
         shifting <= 1'b0;
         drdy_q   <= 1'b1;
         pend_q   <= 1'b0;
         inval_q  <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         if (res_stb) begin
            frame_q  <= frame_d;
            len_q    <= len_d;
            bit_pos  <= '0;
            shifting <= 1'b0;
            drdy_q   <= 1'b0;
            pend_q   <= 1'b1;
            inval_q  <= 1'b0;
         end else begin
            if (!cs_act) begin
               bit_pos  <= '0;
               shifting <= 1'b0;
            end else if (sclk_rise) begin
               dout_q   <= frame_q[bit_idx];
               shifting <= 1'b1;
               bit_pos  <= last_bit ? '0 : bit_pos + CNT_W'(1);
            end
            if (sclk_fall) drdy_q <= 1'b1;
            if ((sclk_rise || sclk_fall) && pend_q) begin
               if (cs_act) pend_q  <= 1'b0;
               else        inval_q <= 1'b1;
            end
         end
      end
   end

   rb_cmd_snoop u_cmd (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
      .din_s(din_s), .cmd_seen(cmd_seen), .cmd_byte(cmd_byte));

   assign dout         = shifting ? dout_q : drdy_q;
   assign dout_oe      = cs_act;
   assign drdy_n       = drdy_q;
   assign data_invalid = inval_q;
endmodule

// File: rtl/rb_checker.sv
module rb_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       res_stb,
   input logic       drdy_n,
   input logic       cmd_seen,
   input logic [7:0] cmd_byte,
   input logic       data_invalid,
   input logic       fall_i,
   input logic       cs_act_i,
   input logic       at_start_i
);
   assert_ready_low_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      res_stb |=> !drdy_n);

   assert_ready_high_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_i && !res_stb) |=> drdy_n);

   assert_cmd_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_seen |-> (cmd_byte != 8'h00));

   assert_cmd_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_seen |=> !cmd_seen);

   assert_invalid_cleared_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_stb |=> !data_invalid);

   assert_cs_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act_i |=> at_start_i);
endmodule

bind adc_readback_shifter rb_checker u_rb_checker (
   .clk(clk), .rst_n(rst_n), .res_stb(res_stb), .drdy_n(drdy_n),
   .cmd_seen(cmd_seen), .cmd_byte(cmd_byte), .data_invalid(data_invalid),
   .fall_i(sclk_fall), .cs_act_i(cs_act), .at_start_i(bit_pos == '0));

// File: tb/tb_adc_readback_shifter.sv
`timescale 1ns/1ps
module tb_adc_readback_shifter;
   localparam int W    = 16;
   localparam int HALF = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, res_stb = 1'b0;
   logic [W-1:0] res_word = '0;
   logic [7:0] res_status = '0;
   logic en_status = 1'b0, en_crc = 1'b0;
   logic dout, dout_oe, drdy_n, cmd_seen, data_invalid;
   logic [7:0] cmd_byte;

   int n_tests = 0, n_fail = 0, cmd_cnt = 0;
   logic [7:0] last_cmd = '0;
   bit exp_q[$];
   bit din_q[$];
   bit finished = 0;

   always #4 clk = ~clk;

   adc_readback_shifter #(.WORD_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .res_stb(res_stb), .res_word(res_word), .res_status(res_status),
      .en_status(en_status), .en_crc(en_crc), .dout(dout), .dout_oe(dout_oe),
      .drdy_n(drdy_n), .cmd_seen(cmd_seen), .cmd_byte(cmd_byte),
      .data_invalid(data_invalid));

   always @(negedge clk) if (cmd_seen) begin cmd_cnt++; last_cmd = cmd_byte; end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_crc(input bit bits[$]);
      logic [7:0] c = 8'h00;
      foreach (bits[i]) c = (c[7] ^ bits[i]) ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
      return c;
   endfunction

   // expected frame per R1 / R5, captured at load time (R11)
   task automatic expect_frame(input bit es, input bit ec, input logic [W-1:0] w, input logic [7:0] st);
      bit covered[$];
      logic [7:0] c;
      exp_q.delete();
      if (es) for (int i = 7; i >= 0; i--) begin exp_q.push_back(st[i]); covered.push_back(st[i]); end
      for (int i = W-1; i >= 0; i--) begin exp_q.push_back(w[i]); covered.push_back(w[i]); end
      c = ref_crc(covered);
      if (ec) for (int i = 7; i >= 0; i--) exp_q.push_back(c[i]);
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(input bit es, input bit ec, input logic [W-1:0] w, input logic [7:0] st);
      @(negedge clk);
      en_status = es; en_crc = ec; res_word = w; res_status = st; res_stb = 1'b1;
      @(negedge clk);
      res_stb = 1'b0;
      expect_frame(es, ec, w, st);
   endtask

   task automatic read_bits(input int n, input int start, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sclk = 1'b1;
         din  = (din_q.size() > 0) ? din_q.pop_front() : 1'b0;
         wait_clk(HALF);
         chk(req, {31'd0, dout}, {31'd0, exp_q[(start + i) % exp_q.size()]});
         sclk = 1'b0;
         wait_clk(HALF);
      end
   endtask

   task automatic push_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) din_q.push_back(b[i]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      // R10 reset state
      chk("R10 drdy_n", {31'd0, drdy_n}, 32'd1);
      chk("R10 dout_oe", {31'd0, dout_oe}, 32'd0);
      chk("R10 cmd_seen", {31'd0, cmd_seen}, 32'd0);
      chk("R10 data_invalid", {31'd0, data_invalid}, 32'd0);
      cs_n = 1'b0; wait_clk(6);
      expect_frame(1'b0, 1'b0, '0, '0);
      read_bits(8, 0, "R10 zero frame");
      cs_n = 1'b1; wait_clk(6);

      // R1 R3 R4 R5: full frame with status and CRC
      cs_n = 1'b0; wait_clk(6);
      load(1'b1, 1'b1, 16'hA35C, 8'h81);
      wait_clk(1);
      chk("R3 drdy low after load", {31'd0, drdy_n}, 32'd0);
      chk("R4 pin shows ready", {31'd0, dout}, 32'd0);
      chk("R4 oe with cs low", {31'd0, dout_oe}, 32'd1);
      read_bits(32, 0, "R1 R5 status word crc");
      chk("R3 drdy high after fall", {31'd0, drdy_n}, 32'd1);
      read_bits(32, 0, "R2 frame repeats");

      // R8: chip select high mid-frame restarts
      read_bits(5, 0, "R2 third pass");
      cs_n = 1'b1; wait_clk(6);
      chk("R4 oe off with cs high", {31'd0, dout_oe}, 32'd0);
      cs_n = 1'b0; wait_clk(6);
      chk("R4 pin shows idle ready", {31'd0, dout}, 32'd1);
      read_bits(10, 0, "R8 restart at first bit");
      cs_n = 1'b1; wait_clk(6);

      // R1: status only, then bare word repeating
      cs_n = 1'b0; wait_clk(6);
      load(1'b1, 1'b0, 16'h0FF0, 8'h3C);
      read_bits(30, 0, "R1 status only");
      cs_n = 1'b1; wait_clk(6); cs_n = 1'b0; wait_clk(6);
      load(1'b0, 1'b0, 16'h1234, 8'hEE);
      read_bits(40, 0, "R2 bare word repeat");
      cs_n = 1'b1; wait_clk(6); cs_n = 1'b0; wait_clk(6);

      // R5: CRC only, R11: enables changed after load
      load(1'b0, 1'b1, 16'hFFFF, 8'h00);
      en_crc = 1'b0; en_status = 1'b1;
      read_bits(24, 0, "R5 R11 crc only");
      cs_n = 1'b1; wait_clk(6); cs_n = 1'b0; wait_clk(6);

      // R6: command snooping
      load(1'b1, 1'b1, 16'h5A5A, 8'h07);
      cmd_cnt = 0;
      push_byte(8'h00);
      read_bits(8, 0, "R6 frame during zero byte");
      wait_clk(4);
      chk("R6 zero byte ignored", cmd_cnt, 32'd0);
      push_byte(8'hA5);
      read_bits(8, 8, "R6 frame during command");
      wait_clk(4);
      chk("R6 command pulse count", cmd_cnt, 32'd1);
      chk("R6 command byte", {24'd0, last_cmd}, 32'h0000_00A5);

      // R9: load during read replaces frame
      read_bits(3, 16, "R9 before overwrite");
      load(1'b0, 1'b1, 16'hC001, 8'h00);
      wait_clk(1);
      chk("R9 pin shows ready after reload", {31'd0, dout}, 32'd0);
      read_bits(24, 0, "R9 new frame from start");
      cs_n = 1'b1; wait_clk(6);

      // R7: activity before read
      load(1'b1, 1'b0, 16'h7777, 8'h11);
      sclk = 1'b1; wait_clk(HALF); sclk = 1'b0; wait_clk(HALF);
      chk("R7 invalid set", {31'd0, data_invalid}, 32'd1);
      load(1'b1, 1'b0, 16'h7777, 8'h11);
      wait_clk(1);
      chk("R7 invalid cleared by load", {31'd0, data_invalid}, 32'd0);
      cs_n = 1'b0; wait_clk(6);
      read_bits(8, 0, "R7 clean read data");
      chk("R7 clean read keeps flag clear", {31'd0, data_invalid}, 32'd0);
      cs_n = 1'b1; wait_clk(6);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule